// File: doc/BRIEF.md
# Ten-to-One TMDS Serializer

This block turns parallel 10-bit TMDS characters into serial bit pairs for a DVI/HDMI style transmitter. The pixel-clock side hands over one character per data lane each pixel period. The serial side runs on a fast clock at five times the pixel rate and emits two bits per fast cycle. A later double-data-rate output stage, which is not part of this block, turns those pairs into the line rate. A fourth lane carries the link clock. It is made by serialising a fixed character whose lower half is zeros and upper half is ones, so it completes one period per character time.

The pixel-side words are captured in a holding register. A toggle flag crosses into the fast domain through a short synchroniser chain, and the edge of that flag makes a one-cycle load strobe. On that strobe each lane shift register takes its word. The register then shifts right by two bits on each of the following fast cycles. Both clocks must come from one source, with the fast clock at exactly (character width / 2) times the pixel clock.

Top module: `tmds_serializer_10to1`

## Requirements
- R1: The packed input `pix_words` holds one character per data lane. Bits [9:0] go to lane 0 (blue), [19:10] to lane 1 (green) and [29:20] to lane 2 (red). Output index 3 is the clock lane.
- R2: Each character leaves its lane least significant bit first, as five pairs. Pair k shows character bit 2k on `ser_even` and bit 2k+1 on `ser_odd`.
- R3: The clock lane sends the constant character 10'b1111100000 in the same order. Its pairs (odd,even) are therefore 00, 00, 10, 11, 11 for k = 0..4.
- R4: The shift registers reload exactly every five fast cycles, and the load strobe lasts one fast cycle. Characters from consecutive pixel periods follow each other with no gap or repeated pair.
- R5: A character is captured at a pixel-clock edge that is also a fast-clock edge. Its first pair is visible after the third fast edge from that point (SYNC_STAGES+1). After the second fast edge the lane still shows the last pair of the previous character.
- R6: While `rst_n` is low, all eight outputs read zero after the first fast edge, whatever `pix_words` carries.
- R7: Pulling `rst_n` low in the middle of a character clears every output at the next fast edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Pixel clock; characters are captured on its rising edge |
| fast_clk | input | 1 | Serial clock, five times the pixel clock, edge-aligned with it |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both clock domains |
| pix_words | input | DATA_LANES*CHAR_W (30) | Parallel characters, lane 0 in the low bits |
| ser_even | output | DATA_LANES+1 (4) | First-sent bit of the current pair per lane; index 3 is the clock lane |
| ser_odd | output | DATA_LANES+1 (4) | Second-sent bit of the current pair per lane |

## Verification
The bench builds the block with its default values: CHAR_W = 10, DATA_LANES = 3 and SYNC_STAGES = 2. With these values the load strobe arrives three fast edges after the pixel edge, so every pair of a character can be sampled at a known fast cycle. The bench also checks the pair just before that window and the first pair after it. Bit-pattern characters exercise all ten bit positions on each lane. Two stimulus windows go through reset: a full reset with all-ones inputs and an abort in the middle of a character.

// File: rtl/tmds_ser_pkg.sv
`timescale 1ns / 1ps
package tmds_ser_pkg;

  localparam int PATTERN_MAX = 32;

  // Clock-lane character: zeros in the lower half, ones in the upper half.
  function automatic logic [PATTERN_MAX-1:0] clock_pattern(input int width);
    logic [PATTERN_MAX-1:0] w;
    w = '0;
    for (int i = 0; i < PATTERN_MAX; i++) begin
      if (i < width && i >= width / 2) w[i] = 1'b1;
    end
    return w;
  endfunction

endpackage

// File: rtl/tmds_pix_capture.sv
`timescale 1ns / 1ps
module tmds_pix_capture #(
  parameter int WORD_W = 30
) (
  input  logic              pix_clk,
  input  logic              rst_hi,
  input  logic [WORD_W-1:0] words_in,
  output logic [WORD_W-1:0] words_held,
  output logic              word_flag
);
  // Holding register plus a flag that flips once per pixel period.
  always_ff @(posedge pix_clk) begin
    if (rst_hi) begin
      words_held <= '0;
      word_flag  <= 1'b0;
    end else begin
      words_held <= words_in;
      word_flag  <= ~word_flag;
    end
  end
endmodule

// File: rtl/tmds_load_sync.sv
`timescale 1ns / 1ps
module tmds_load_sync #(
  parameter int STAGES = 2
) (
  input  logic fast_clk,
  input  logic rst_hi,
  input  logic flag_in,
  output logic load
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge fast_clk) begin
    if (rst_hi) chain <= '0;
    else        chain <= {chain[CHAIN_W-2:0], flag_in};
  end

  // Any change of the synchronised flag marks a fresh character.
  assign load = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/tmds_lane_shifter.sv
`timescale 1ns / 1ps
module tmds_lane_shifter #(
  parameter int CHAR_W = 10
) (
  input  logic              fast_clk,
  input  logic              rst_hi,
  input  logic              load,
  input  logic [CHAR_W-1:0] word,
  output logic              bit_even,
  output logic              bit_odd
);
  logic [CHAR_W-1:0] sr;

  function automatic logic [CHAR_W-1:0] drop_pair(input logic [CHAR_W-1:0] v);
    return {2'b00, v[CHAR_W-1:2]};
  endfunction

  always_ff @(posedge fast_clk) begin
    if (rst_hi)    sr <= '0;
    else if (load) sr <= word;
    else           sr <= drop_pair(sr);
  end

  assign bit_even = sr[0];
  assign bit_odd  = sr[1];
endmodule

// File: rtl/tmds_serializer_10to1.sv
`timescale 1ns / 1ps
module tmds_serializer_10to1
  import tmds_ser_pkg::*;
#(
  parameter int CHAR_W      = 10,
  parameter int DATA_LANES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         pix_clk,
  input  logic                         fast_clk,
  input  logic                         rst_n,
  input  logic [DATA_LANES*CHAR_W-1:0] pix_words,
  output logic [DATA_LANES:0]          ser_even,
  output logic [DATA_LANES:0]          ser_odd
);
  localparam int BUS_W    = DATA_LANES * CHAR_W;
  localparam int CLK_LANE = DATA_LANES;
  localparam logic [CHAR_W-1:0] CLK_WORD = CHAR_W'(clock_pattern(CHAR_W));

  logic             rst_hi;
  logic [BUS_W-1:0] cap_words;
  logic             cap_flag;
  logic             load_pulse;

  assign rst_hi = ~rst_n;

  tmds_pix_capture #(.WORD_W(BUS_W)) u_capture (
    .pix_clk   (pix_clk),
    .rst_hi    (rst_hi),
    .words_in  (pix_words),
    .words_held(cap_words),
    .word_flag (cap_flag)
  );

  tmds_load_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .fast_clk(fast_clk),
    .rst_hi  (rst_hi),
    .flag_in (cap_flag),
    .load    (load_pulse)
  );

  for (genvar g = 0; g < DATA_LANES; g++) begin : g_data_lane
    tmds_lane_shifter #(.CHAR_W(CHAR_W)) u_shift (
      .fast_clk(fast_clk),
      .rst_hi  (rst_hi),
      .load    (load_pulse),
      .word    (cap_words[g*CHAR_W +: CHAR_W]),
      .bit_even(ser_even[g]),
      .bit_odd (ser_odd[g])
    );
  end

  tmds_lane_shifter #(.CHAR_W(CHAR_W)) u_clk_shift (
    .fast_clk(fast_clk),
    .rst_hi  (rst_hi),
    .load    (load_pulse),
    .word    (CLK_WORD),
    .bit_even(ser_even[CLK_LANE]),
    .bit_odd (ser_odd[CLK_LANE])
  );
endmodule

// File: rtl/tmds_serializer_checks.sv
`timescale 1ns / 1ps
module tmds_serializer_checks #(
  parameter int CHAR_W     = 10,
  parameter int DATA_LANES = 3
) (
  input logic                fast_clk,
  input logic                rst_hi,
  input logic                load_pulse,
  input logic [1:0]          lane0_low_pair,
  input logic [DATA_LANES:0] ser_even,
  input logic [DATA_LANES:0] ser_odd
);
  localparam int PAIRS = CHAR_W / 2;
  localparam int GAP_W = $clog2(CHAR_W) + 1;
  localparam int CL    = DATA_LANES;

  logic [GAP_W-1:0] gap;
  logic             seen;

  always_ff @(posedge fast_clk) begin
    if (rst_hi) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (load_pulse) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != {GAP_W{1'b1}}) begin
      gap <= gap + 1'b1;
    end
  end

  p_reload_period_r4: assert property (@(posedge fast_clk) disable iff (rst_hi)
    (load_pulse && seen) |-> (gap == GAP_W'(PAIRS - 1)));

  p_strobe_single_r4: assert property (@(posedge fast_clk) disable iff (rst_hi)
    load_pulse |=> !load_pulse);

  p_first_pair_lsb_r2: assert property (@(posedge fast_clk) disable iff (rst_hi)
    load_pulse |=> ({ser_odd[0], ser_even[0]} == $past(lane0_low_pair)));

  p_clk_low_half_r3: assert property (@(posedge fast_clk) disable iff (rst_hi)
    load_pulse |=> ({ser_odd[CL], ser_even[CL]} == 2'b00));

  p_clk_high_half_r3: assert property (@(posedge fast_clk) disable iff (rst_hi)
    load_pulse |=> ##3 ({ser_odd[CL], ser_even[CL]} == 2'b11));

  p_reset_quiet_r6: assert property (@(posedge fast_clk)
    rst_hi |=> (ser_even == '0 && ser_odd == '0));
endmodule

bind tmds_serializer_10to1 tmds_serializer_checks #(
  .CHAR_W    (CHAR_W),
  .DATA_LANES(DATA_LANES)
) u_checks (
  .fast_clk      (fast_clk),
  .rst_hi        (rst_hi),
  .load_pulse    (load_pulse),
  .lane0_low_pair(cap_words[1:0]),
  .ser_even      (ser_even),
  .ser_odd       (ser_odd)
);

// File: tb/tmds_serializer_10to1_test.sv
`timescale 1ns / 1ps
module tmds_serializer_10to1_test;
  localparam int NV = 8;
  localparam logic [29:0] VEC [NV] = '{
    {10'h3FF, 10'h000, 10'h155},
    {10'h000, 10'h3FF, 10'h2AA},
    {10'h001, 10'h200, 10'h0F0},
    {10'h2AA, 10'h155, 10'h30F},
    {10'h123, 10'h2DC, 10'h0A5},
    {10'h3E0, 10'h01F, 10'h11B},
    {10'h000, 10'h000, 10'h000},
    {10'h3FF, 10'h3FF, 10'h3FF}
  };
  localparam logic [9:0] CLK_CHAR = 10'b1111100000;

  logic        pix_clk = 1'b0;
  logic        fast_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] pix_words = '1;
  logic [3:0]  ser_even;
  logic [3:0]  ser_odd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 fast_clk = ~fast_clk;   // 50 MHz serial clock
  always #50 pix_clk  = ~pix_clk;    // one fifth of it

  tmds_serializer_10to1 uut (
    .pix_clk  (pix_clk),
    .fast_clk (fast_clk),
    .rst_n    (rst_n),
    .pix_words(pix_words),
    .ser_even (ser_even),
    .ser_odd  (ser_odd)
  );

  function automatic logic [1:0] pair_of(input logic [9:0] ch, input int k);
    return {ch[2*k+1], ch[2*k]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #3000000;
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [29:0] prev;
    // R6: reset holds every lane quiet with all-ones inputs
    repeat (4) begin
      @(negedge fast_clk);
      chk("R6 reset outputs", {ser_odd, ser_even}, 8'h00);
    end
    @(negedge pix_clk);
    pix_words = '0;
    @(negedge pix_clk);
    rst_n = 1'b1;
    repeat (3) @(negedge pix_clk);
    prev = '0;

    for (int v = 0; v < NV; v++) begin
      @(negedge pix_clk);
      pix_words = VEC[v];
      @(posedge pix_clk);
      @(negedge fast_clk);
      repeat (2) @(negedge fast_clk);
      // R5: one edge before the window the old character is still ending
      chk("R5 previous tail", {6'b0, ser_odd[0], ser_even[0]}, {6'b0, pair_of(prev[9:0], 4)});
      @(negedge fast_clk);
      for (int j = 0; j < 6; j++) begin
        for (int ln = 0; ln < 3; ln++) begin
          string tag;
          if (j == 0)       tag = "R5 first pair";
          else if (j == 5)  tag = "R4 back-to-back";
          else if (ln == 2) tag = "R1 red lane";
          else              tag = "R2 pair order";
          chk(tag, {6'b0, ser_odd[ln], ser_even[ln]},
              {6'b0, pair_of(VEC[v][ln*10 +: 10], j % 5)});
        end
        chk("R3 clock lane", {6'b0, ser_odd[3], ser_even[3]}, {6'b0, pair_of(CLK_CHAR, j % 5)});
        if (j < 5) @(negedge fast_clk);
      end
      prev = VEC[v];
    end

    // R7: abort in the middle of a character
    @(negedge pix_clk);
    pix_words = '1;
    @(posedge pix_clk);
    @(negedge fast_clk);
    repeat (4) @(negedge fast_clk);
    chk("R2 mid-char data", {6'b0, ser_odd[0], ser_even[0]}, 8'h03);
    rst_n = 1'b0;
    @(negedge fast_clk);
    chk("R7 mid-char reset", {ser_odd, ser_even}, 8'h00);
    @(negedge fast_clk);
    chk("R6 reset held", {ser_odd, ser_even}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge fast_clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule